// File: doc/BRIEF.md
# Multi-destination interrupt priority resolver

This block sits between a bank of pending interrupt lines and three consumers: the processor, a data-transfer controller and a DMA controller. Each source carries a fixed vector number equal to `VEC_BASE` plus its index. A per-source 2-bit route code steers it to one of the three consumers. For the processor, a 3-bit level selects the winner, and equal levels go to the smaller vector. A fast-interrupt setting can promote one chosen vector above everything else. For the transfer controller, the smallest pending vector wins and levels play no part. The DMA side gets its routed request lines unchanged, with no arbitration.

Software fills the levels, route codes and the fast-interrupt setting through a one-cycle write port. The processor and transfer-controller results are registered. Each result is held steady until the consumer acknowledges it. The cycle after an acknowledge carries no request, and the next winner appears in the cycle after that.

Top module: `irq_route_arbiter`

## Requirements
- R1: Route code 2'b00 sends a source to the processor side, 2'b01 to the transfer-controller side, and 2'b10 or 2'b11 to the DMA side; a source counts only on the side its code selects.
- R2: Among pending processor-side sources, the one with the numerically largest level wins, and `cpu_level` reports that level.
- R3: When several pending processor-side sources share the highest level, the smallest vector number wins.
- R4: A processor-side source with level 0 never wins; with no eligible candidate `cpu_req` stays low.
- R5: With the fast enable set, the source whose vector equals the fast vector wins if it is pending and routed to the processor, whatever its level (even 0), and `cpu_level` reads 7.
- R6: While `in_service_max` is high, the fast source is withheld from the processor side (other sources compete normally). It is presented as soon as a new selection happens with `in_service_max` low.
- R7: The fast setting changes nothing on the transfer-controller or DMA outputs.
- R8: Among pending transfer-controller sources, the smallest vector wins regardless of level.
- R9: `dma_req[i]` equals, one cycle later, `pend[i]` masked by source i being DMA-routed.
- R10: Results are registered: a winner appears one clock after it is selected. While `cpu_req` (or `dtc_req`) is high and not acknowledged, its vector and level stay unchanged, even if pending lines change.
- R11: An acknowledge clears that side's request in the next cycle. The following cycle then carries the winner of the pending lines at that time.
- R12: Writes take effect on the clock edge where `wr_en` is high. `wr_kind` 0 writes `wr_data[2:0]` as the level of source `wr_idx`, 1 writes `wr_data[1:0]` as its route code, and 2 writes the fast setting (enable `wr_data[8]`, vector `wr_data[7:0]`). Reset clears all levels, route codes and the fast setting, and drives all requests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | N | Level-sensitive pending lines, bit i is vector VEC_BASE+i |
| in_service_max | input | 1 | Processor is handling a top-level or non-maskable interrupt |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 2 | Write target: 0 level, 1 route code, 2 fast setting |
| wr_idx | input | IDX_W | Source index for level and route writes |
| wr_data | input | VEC_W+1 | Write data |
| cpu_req | output | 1 | Processor request valid |
| cpu_vector | output | VEC_W | Winning processor vector |
| cpu_level | output | LVL_W | Effective level of the processor winner |
| cpu_ack | input | 1 | Processor acknowledge |
| dtc_req | output | 1 | Transfer-controller request valid |
| dtc_vector | output | VEC_W | Winning transfer-controller vector |
| dtc_ack | input | 1 | Transfer-controller acknowledge |
| dma_req | output | N | Registered DMA-routed pending lines |

## Verification
The hardest case to reach is a fast interrupt being withheld and then released. This needs the fast source pending and routed to the processor, a competitor that can win on its own, and `in_service_max` toggling between two selections. Random stimulus seldom lines these up. Directed sequences therefore build that setup explicitly and check both selections. Random rounds also reprogram the fast vector, sometimes outside the source range or onto a non-processor source, and set `in_service_max` at random. A pending-line change is injected while each result is held, to show that a better late arrival does not disturb a standing request.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    typedef enum logic [1:0] {
        KIND_LEVEL = 2'd0,
        KIND_ROUTE = 2'd1,
        KIND_FAST  = 2'd2,
        KIND_NONE  = 2'd3
    } wr_kind_e;

    localparam logic [1:0] ROUTE_CPU = 2'b00;
    localparam logic [1:0] ROUTE_DTC = 2'b01;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_route_pkg::*;
#(
    parameter int N     = 32,
    parameter int VEC_W = 8,
    parameter int LVL_W = 3,
    parameter int IDX_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [1:0]                 wr_kind_i,
    input  logic [IDX_W-1:0]           wr_idx_i,
    input  logic [VEC_W:0]             wr_data_i,
    output logic [N-1:0][LVL_W-1:0]    level_o,
    output logic [N-1:0][1:0]          route_o,
    output logic                       fast_en_o,
    output logic [VEC_W-1:0]           fast_vec_o
);
    typedef struct packed {
        logic [N-1:0][LVL_W-1:0] level;
        logic [N-1:0][1:0]       route;
        logic                    fast_en;
        logic [VEC_W-1:0]        fast_vec;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (wr_kind_e'(wr_kind_i))
                KIND_LEVEL: begin
                    for (int i = 0; i < N; i++) begin
                        if (int'(wr_idx_i) == i) cfg_d.level[i] = wr_data_i[LVL_W-1:0];
                    end
                end
                KIND_ROUTE: begin
                    for (int i = 0; i < N; i++) begin
                        if (int'(wr_idx_i) == i) cfg_d.route[i] = wr_data_i[1:0];
                    end
                end
                KIND_FAST: begin
                    cfg_d.fast_en  = wr_data_i[VEC_W];
                    cfg_d.fast_vec = wr_data_i[VEC_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign level_o    = cfg_q.level;
    assign route_o    = cfg_q.route;
    assign fast_en_o  = cfg_q.fast_en;
    assign fast_vec_o = cfg_q.fast_vec;

    // R12: a fast write lands on the next edge
    p_fast_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_kind_i == 2'd2) |=> (fast_vec_o == $past(wr_data_i[VEC_W-1:0])));
endmodule

// File: rtl/irq_cpu_arb.sv
module irq_cpu_arb #(
    parameter int N        = 32,
    parameter int VEC_BASE = 64,
    parameter int VEC_W    = 8,
    parameter int LVL_W    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            cand_i,
    input  logic [N-1:0][LVL_W-1:0] level_i,
    input  logic                    fast_en_i,
    input  logic [VEC_W-1:0]        fast_vec_i,
    input  logic                    in_service_max_i,
    input  logic                    ack_i,
    output logic                    req_o,
    output logic [VEC_W-1:0]        vec_o,
    output logic [LVL_W-1:0]        level_o
);
    localparam logic [LVL_W-1:0] TOP_LVL = '1;

    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] vec;
        logic [LVL_W-1:0] level;
    } res_t;

    res_t res_d, res_q;

    logic [VEC_W-1:0] fast_ofs;
    logic             fast_in_range;
    logic             fast_hit;
    logic             norm_found;
    logic [VEC_W-1:0] norm_vec;
    logic [LVL_W-1:0] norm_lvl;

    always_comb begin
        fast_ofs      = fast_vec_i - VEC_W'(VEC_BASE);
        fast_in_range = fast_en_i && (fast_vec_i >= VEC_W'(VEC_BASE)) && (int'(fast_ofs) < N);
        fast_hit      = 1'b0;
        norm_found    = 1'b0;
        norm_vec      = '0;
        norm_lvl      = '0;
        for (int i = 0; i < N; i++) begin
            if (fast_in_range && int'(fast_ofs) == i) begin
                fast_hit = cand_i[i];
            end else if (cand_i[i] && level_i[i] != '0 &&
                         (!norm_found || level_i[i] > norm_lvl)) begin
                norm_found = 1'b1;
                norm_vec   = VEC_W'(VEC_BASE + i);
                norm_lvl   = level_i[i];
            end
        end
    end

    always_comb begin
        res_d = res_q;
        if (ack_i) begin
            res_d.req = 1'b0;
        end else if (!res_q.req) begin
            if (fast_hit && !in_service_max_i) begin
                res_d.req   = 1'b1;
                res_d.vec   = fast_vec_i;
                res_d.level = TOP_LVL;
            end else begin
                res_d.req   = norm_found;
                res_d.vec   = norm_vec;
                res_d.level = norm_lvl;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign req_o   = res_q.req;
    assign vec_o   = res_q.vec;
    assign level_o = res_q.level;

    p_hold_cpu_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(vec_o) && $stable(level_o)));

    p_ack_cpu_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !req_o);

    p_no_zero_lvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (level_o != '0));

    p_fast_withheld_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !ack_i && in_service_max_i && fast_en_i)
        |=> !(req_o && vec_o == $past(fast_vec_i)));
endmodule

// File: rtl/irq_dtc_arb.sv
module irq_dtc_arb #(
    parameter int N        = 32,
    parameter int VEC_BASE = 64,
    parameter int VEC_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     cand_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o
);
    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] vec;
    } res_t;

    res_t             res_d, res_q;
    logic             low_found;
    logic [VEC_W-1:0] low_vec;

    always_comb begin
        low_found = 1'b0;
        low_vec   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                low_found = 1'b1;
                low_vec   = VEC_W'(VEC_BASE + i);
            end
        end
    end

    always_comb begin
        res_d = res_q;
        if (ack_i) begin
            res_d.req = 1'b0;
        end else if (!res_q.req) begin
            res_d.req = low_found;
            res_d.vec = low_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign req_o = res_q.req;
    assign vec_o = res_q.vec;

    p_hold_dtc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(vec_o)));

    p_ack_dtc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !req_o);

    p_dtc_found_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !ack_i && cand_i != '0) |=> req_o);
endmodule

// File: rtl/irq_route_arbiter.sv
module irq_route_arbiter
    import irq_route_pkg::*;
#(
    parameter int N        = 32,
    parameter int VEC_BASE = 64,
    parameter int VEC_W    = 8,
    parameter int LVL_W    = 3,
    localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pend_i,
    input  logic             in_service_max,
    input  logic             wr_en,
    input  logic [1:0]       wr_kind,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VEC_W:0]   wr_data,
    output logic             cpu_req,
    output logic [VEC_W-1:0] cpu_vector,
    output logic [LVL_W-1:0] cpu_level,
    input  logic             cpu_ack,
    output logic             dtc_req,
    output logic [VEC_W-1:0] dtc_vector,
    input  logic             dtc_ack,
    output logic [N-1:0]     dma_req
);
    logic [N-1:0][LVL_W-1:0] level;
    logic [N-1:0][1:0]       route;
    logic                    fast_en;
    logic [VEC_W-1:0]        fast_vec;
    logic [N-1:0]            cpu_cand, dtc_cand, dma_cand;
    logic [N-1:0]            dma_d, dma_q;

    irq_cfg_regs #(.N(N), .VEC_W(VEC_W), .LVL_W(LVL_W), .IDX_W(IDX_W)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_kind_i  (wr_kind),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (wr_data),
        .level_o    (level),
        .route_o    (route),
        .fast_en_o  (fast_en),
        .fast_vec_o (fast_vec)
    );

    for (genvar g = 0; g < N; g++) begin : g_route
        assign cpu_cand[g] = pend_i[g] && (route[g] == ROUTE_CPU);
        assign dtc_cand[g] = pend_i[g] && (route[g] == ROUTE_DTC);
        assign dma_cand[g] = pend_i[g] && route[g][1];
    end

    irq_cpu_arb #(.N(N), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W), .LVL_W(LVL_W)) cpu_arb_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .cand_i           (cpu_cand),
        .level_i          (level),
        .fast_en_i        (fast_en),
        .fast_vec_i       (fast_vec),
        .in_service_max_i (in_service_max),
        .ack_i            (cpu_ack),
        .req_o            (cpu_req),
        .vec_o            (cpu_vector),
        .level_o          (cpu_level)
    );

    irq_dtc_arb #(.N(N), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W)) dtc_arb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (dtc_cand),
        .ack_i  (dtc_ack),
        .req_o  (dtc_req),
        .vec_o  (dtc_vector)
    );

    always_comb begin
        dma_d = dma_cand;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dma_q <= '0;
        else        dma_q <= dma_d;
    end

    assign dma_req = dma_q;

    p_dma_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dma_req & ~$past(pend_i)) == '0));

    p_route_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({|(cpu_cand & dtc_cand), |(cpu_cand & dma_cand), |(dtc_cand & dma_cand)}) == 0);
endmodule

// File: tb/irq_route_arbiter_tb_top.sv
module irq_route_arbiter_tb_top;
    localparam int N        = 32;
    localparam int VEC_BASE = 64;
    localparam int VEC_W    = 8;
    localparam int LVL_W    = 3;
    localparam int IDX_W    = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     pend_i = '0;
    logic             in_service_max = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_kind = '0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [VEC_W:0]   wr_data = '0;
    logic             cpu_req, dtc_req, cpu_ack = 1'b0, dtc_ack = 1'b0;
    logic [VEC_W-1:0] cpu_vector, dtc_vector;
    logic [LVL_W-1:0] cpu_level;
    logic [N-1:0]     dma_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [2:0] lvl_m [N];
    logic [1:0] rte_m [N];
    logic       fen_m = 1'b0;
    logic [7:0] fvec_m = '0;

    always #5 clk = ~clk;

    irq_route_arbiter #(.N(N), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W), .LVL_W(LVL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .in_service_max(in_service_max),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .cpu_req(cpu_req), .cpu_vector(cpu_vector), .cpu_level(cpu_level), .cpu_ack(cpu_ack),
        .dtc_req(dtc_req), .dtc_vector(dtc_vector), .dtc_ack(dtc_ack), .dma_req(dma_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] kind, input int idx, input logic [8:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = kind; wr_idx = IDX_W'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (kind == 2'd0) lvl_m[idx] = data[2:0];
        if (kind == 2'd1) rte_m[idx] = data[1:0];
        if (kind == 2'd2) begin fen_m = data[8]; fvec_m = data[7:0]; end
    endtask

    function automatic void model_cpu(input logic [N-1:0] p, input logic ism,
                                      output logic v, output logic [7:0] vec, output logic [2:0] lv);
        int  fidx = int'(fvec_m) - VEC_BASE;
        bit  fin  = fen_m && fidx >= 0 && fidx < N;
        v = 1'b0; vec = '0; lv = '0;
        if (fin && !ism && p[fidx] && rte_m[fidx] == 2'b00) begin
            v = 1'b1; vec = fvec_m; lv = 3'd7;
            return;
        end
        for (int i = 0; i < N; i++) begin
            if (p[i] && rte_m[i] == 2'b00 && lvl_m[i] != 0 && !(fin && i == fidx)
                && (!v || lvl_m[i] > lv)) begin
                v = 1'b1; vec = 8'(VEC_BASE + i); lv = lvl_m[i];
            end
        end
    endfunction

    function automatic void model_dtc(input logic [N-1:0] p, output logic v, output logic [7:0] vec);
        v = 1'b0; vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (p[i] && rte_m[i] == 2'b01) begin v = 1'b1; vec = 8'(VEC_BASE + i); end
        end
    endfunction

    function automatic logic [N-1:0] model_dma(input logic [N-1:0] p);
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) m[i] = p[i] && rte_m[i][1];
        return m;
    endfunction

    // Acknowledge both sides, then let the new pending set be selected and check it.
    task automatic apply(input logic [N-1:0] p, input logic ism, input string tag);
        logic       cv, dv;
        logic [7:0] cvec, dvec;
        logic [2:0] clv;
        @(negedge clk);
        pend_i = p; in_service_max = ism; cpu_ack = 1'b1; dtc_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0; dtc_ack = 1'b0;
        check({"R11 cleared cpu_req ", tag}, 32'(cpu_req), 32'd0);
        check({"R11 cleared dtc_req ", tag}, 32'(dtc_req), 32'd0);
        check({"R9 dma pass ", tag}, 32'(dma_req), 32'(model_dma(p)));
        @(negedge clk);
        model_cpu(p, ism, cv, cvec, clv);
        model_dtc(p, dv, dvec);
        check({"R2 cpu_req ", tag}, 32'(cpu_req), 32'(cv));
        if (cv) begin
            check({"R3 cpu_vector ", tag}, 32'(cpu_vector), 32'(cvec));
            check({"R5 cpu_level ", tag}, 32'(cpu_level), 32'(clv));
        end
        check({"R8 dtc_req ", tag}, 32'(dtc_req), 32'(dv));
        if (dv) check({"R8 dtc_vector ", tag}, 32'(dtc_vector), 32'(dvec));
    endtask

    // Change the pending lines without acknowledging; held results must not move.
    task automatic perturb(input logic [N-1:0] p2);
        logic       c0, d0;
        logic [7:0] cv0, dv0;
        logic [2:0] cl0;
        c0 = cpu_req; cv0 = cpu_vector; cl0 = cpu_level; d0 = dtc_req; dv0 = dtc_vector;
        @(negedge clk);
        pend_i = p2; in_service_max = 1'b0;
        @(negedge clk);
        if (c0) begin
            check("R10 cpu held req", 32'(cpu_req), 32'd1);
            check("R10 cpu held vector", 32'(cpu_vector), 32'(cv0));
            check("R10 cpu held level", 32'(cpu_level), 32'(cl0));
        end
        if (d0) check("R10 dtc held vector", 32'(dtc_vector), 32'(dv0));
        check("R9 dma follows", 32'(dma_req), 32'(model_dma(p2)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin lvl_m[i] = '0; rte_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 reset cpu_req", 32'(cpu_req), 32'd0);
        check("R12 reset dtc_req", 32'(dtc_req), 32'd0);
        check("R12 reset dma_req", 32'(dma_req), 32'd0);
        // R4: all levels 0 after reset, all routed to CPU: nothing wins
        apply(32'hFFFF_FFFF, 1'b0, "R4 all level0");

        // Directed: levels and ties
        wr(2'd0, 5, 9'd4); wr(2'd0, 9, 9'd4); wr(2'd0, 20, 9'd2);
        apply((32'd1 << 5) | (32'd1 << 9) | (32'd1 << 20), 1'b0, "R3 tie");
        wr(2'd0, 20, 9'd6);
        apply((32'd1 << 5) | (32'd1 << 9) | (32'd1 << 20), 1'b0, "R2 higher");
        check("R2 directed winner", 32'(cpu_vector), 32'(VEC_BASE + 20));

        // Directed: routing to DTC and DMA, levels ignored on DTC
        wr(2'd1, 2, 9'd1); wr(2'd0, 2, 9'd7);
        wr(2'd1, 1, 9'd1); wr(2'd0, 1, 9'd1);
        wr(2'd1, 7, 9'd2); wr(2'd1, 8, 9'd3);
        apply(32'h0000_0186, 1'b0, "R1 routing");
        check("R8 directed dtc lowest", 32'(dtc_vector), 32'(VEC_BASE + 1));
        check("R1 dma codes 10 and 11", 32'(dma_req), 32'h0000_0180);

        // Directed: fast interrupt on a level-0 source, then withheld
        wr(2'd0, 3, 9'd0);
        wr(2'd2, 0, {1'b1, 8'(VEC_BASE + 3)});
        apply((32'd1 << 3) | (32'd1 << 9), 1'b1, "R6 withheld");
        check("R6 directed non-fast winner", 32'(cpu_vector), 32'(VEC_BASE + 9));
        apply((32'd1 << 3) | (32'd1 << 9), 1'b0, "R5 released");
        check("R5 directed fast level", 32'(cpu_level), 32'd7);
        // R7: fast vector pointing at a DTC source changes nothing there
        wr(2'd2, 0, {1'b1, 8'(VEC_BASE + 2)});
        apply(32'h0000_0186, 1'b0, "R7 fast on dtc");
        check("R7 dtc unaffected", 32'(dtc_vector), 32'(VEC_BASE + 1));
        perturb(32'hFFFF_FFFF);

        // Random rounds
        for (int r = 0; r < 400; r++) begin
            if (r % 40 == 0) begin
                for (int i = 0; i < N; i++) begin
                    wr(2'd0, i, 9'($urandom % 8));
                    wr(2'd1, i, 9'(($urandom % 3 == 0) ? ($urandom % 4) : 0));
                end
            end
            if (r % 8 == 0)
                wr(2'd2, 0, {1'($urandom % 2), 8'(VEC_BASE - 2 + int'($urandom % (N + 4)))});
            apply($urandom & $urandom, 1'($urandom % 3 == 0), "random");
            perturb($urandom);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule